// File: doc/BRIEF.md
# Cascadable Presettable Counter

This block is a four-bit synchronous up-counter with a parallel preset, an active-low clear and two count enables. Two parameters set its variant. One selects binary counting (0 to 15) or decade counting (0 to 9). The other makes the clear act on the next rising clock edge or act at once.

A stage counts only when both the count enable and the chain enable are high. Only the chain enable gates the carry output. Clear overrides preset, and preset overrides counting, so either one acts whatever the enable levels are. The carry output is high while the count sits at its top value and the chain enable is high. It is combinational, so a wider counter can be built with carry look-ahead. In that arrangement the lowest stage's carry drives the count enable of every higher stage, and each stage's carry drives the chain enable of the stage above it.

Top module: `cascadable_counter`

## Requirements
- R1: On a rising edge with clear_n and preset_n high and both cnt_en and chain_en high, value advances by one. From the top value (15 binary, 9 decade) it goes to 0.
- R2: On a rising edge with clear_n and preset_n high and either enable low, value keeps its previous contents.
- R3: On a rising edge with clear_n high and preset_n low, value takes preset_val, whatever the levels on cnt_en and chain_en.
- R4: With ASYNC_CLEAR=0, a low clear_n leaves value unchanged until the next rising edge, which then sets value to 0. This holds even when preset_n is low and both enables are high.
- R5: With ASYNC_CLEAR=1, a low clear_n sets value to 0 at once, with no clock edge needed, and holds it there while clear_n stays low.
- R6: carry_out is 1 exactly when chain_en is 1 and value equals the top value (15 binary, 9 decade). cnt_en has no effect on carry_out.
- R7: carry_out follows chain_en between clock edges, with no register in its path.
- R8: In binary mode, a preset of 12 followed by counting gives 13, 14, 15, 0, 1, 2.
- R9: In decade mode, a preset of 7 followed by counting gives 8, 9, 0, 1, 2, 3.
- R10: In decade mode, a preset value of 10 to 15 counts upward in binary until it wraps to 0, and carry_out stays 0 for those values.
- R11: Pulses on preset_n, cnt_en or chain_en that start and end between two rising edges do not change value.
- R12: Three binary stages in look-ahead connection form a 12-bit counter. Each higher stage advances at the same edge on which every stage below it wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clock | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear, synchronous or immediate per ASYNC_CLEAR |
| preset_n | input | 1 | Active-low parallel preset |
| preset_val | input | WIDTH | Value taken on a preset |
| cnt_en | input | 1 | Count enable; does not gate the carry |
| chain_en | input | 1 | Chain enable; gates both counting and carry_out |
| value | output | WIDTH | Current count |
| carry_out | output | 1 | High at the top count while chain_en is high |

## Verification
Counting is driven from a preset of 12 in binary mode and from a preset of 7 in decade mode. These two runs show whether the wrap point follows the mode parameter. A decade preset of 12 shows whether the out-of-range values wrap through 15 and keep the carry low. Enable patterns with only one enable high separate the hold path from the carry path. Preset and enable pulses that fall between edges show whether the register samples only at the edge. A clear applied together with a preset, checked both before and after the edge, separates the synchronous variant from the immediate one and confirms that clear wins over preset. A three-stage chain is preset just below the points where the middle and top stages roll over. It shows whether the look-ahead wiring makes the upper stages step at exactly the right edge.

// File: rtl/cnt_pkg.sv
// Package: shared operation encoding and top-count helper for the counter.
// Assumes: counters no wider than 31 bits.
package cnt_pkg;

    // Next-edge operation, in rising order of priority.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // Largest value a stage reaches before it wraps to zero.
    function automatic int unsigned top_count(input bit decade, input int unsigned width);
        return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
    endfunction

endpackage

// File: rtl/cnt_ctrl.sv
// Module: cnt_ctrl
// Picks the operation the next rising edge will perform.
// Order of priority: clear, preset, count, hold.
// Assumes: all inputs are settled before the edge.
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic    clear_n,
    input  logic    preset_n,
    input  logic    cnt_en,
    input  logic    chain_en,
    output cnt_op_e op
);

    // Priority decode of the control inputs.
    always_comb begin
        if (!clear_n)
            op = OP_CLEAR;
        else if (!preset_n)
            op = OP_LOAD;
        else if (cnt_en && chain_en)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_next.sv
// Module: cnt_next
// Computes the value the register will take at the next edge.
// When counting, the stage wraps to zero at TOP.
// Above TOP it simply increments, so decade out-of-range values reach 0 through the natural binary wrap.
// Assumes: TOP fits in WIDTH bits.
module cnt_next
    import cnt_pkg::*;
#(
    parameter int unsigned     WIDTH = 4,
    parameter logic [WIDTH-1:0] TOP  = '1
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset_val,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Selects the next value for each operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset_val;
            OP_COUNT: nxt = (cur == TOP) ? '0 : (cur + ONE);
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_state.sv
// Module: cnt_state
// Holds the count.
// ASYNC_CLEAR chooses whether clear_n acts at once (asynchronous) or only at the edge.
// Assumes: clear_n is released clear of the rising edge.
module cnt_state #(
    parameter int unsigned WIDTH       = 4,
    parameter bit          ASYNC_CLEAR = 1'b0
) (
    input  logic             clock,
    input  logic             clear_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);

    generate
        if (ASYNC_CLEAR) begin : g_async
            // Register with immediate clear.
            always_ff @(posedge clock or negedge clear_n) begin
                if (!clear_n)
                    q <= '0;
                else
                    q <= nxt;
            end
        end else begin : g_sync
            // Register whose clear takes effect only at the rising edge.
            always_ff @(posedge clock) begin
                if (!clear_n)
                    q <= '0;
                else
                    q <= nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/cnt_carry.sv
// Module: cnt_carry
// Terminal-count detector.
// The carry is purely combinational, so the chain enable reaches the carry output without waiting for a clock edge.
// Assumes: TOP fits in WIDTH bits.
module cnt_carry #(
    parameter int unsigned      WIDTH = 4,
    parameter logic [WIDTH-1:0] TOP   = '1
) (
    input  logic [WIDTH-1:0] q,
    input  logic             chain_en,
    output logic             carry_out
);

    logic [WIDTH-1:0] bit_match;

    // Bitwise comparison against the top count.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_match
            assign bit_match[i] = (q[i] == TOP[i]);
        end
    endgenerate

    // Carry is raised at the top count, gated by the chain enable.
    always_comb begin
        carry_out = chain_en && (&bit_match);
    end

endmodule

// File: rtl/cascadable_counter.sv
// Module: cascadable_counter
// Presettable synchronous up-counter with two count enables and a look-ahead carry for chaining.
// DECADE=1 makes it count 0..9. ASYNC_CLEAR=1 makes the clear act at once.
// clear_n is the block's only reset.
// Assumes: WIDTH >= 4 when DECADE is set.
module cascadable_counter #(
    parameter int unsigned WIDTH       = 4,
    parameter bit          DECADE      = 1'b0,
    parameter bit          ASYNC_CLEAR = 1'b0
) (
    input  logic             clock,
    input  logic             clear_n,
    input  logic             preset_n,
    input  logic [WIDTH-1:0] preset_val,
    input  logic             cnt_en,
    input  logic             chain_en,
    output logic [WIDTH-1:0] value,
    output logic             carry_out
);

    import cnt_pkg::*;

    localparam logic [WIDTH-1:0] TOP = WIDTH'(top_count(DECADE, WIDTH));

    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;

    cnt_ctrl u_ctrl (
        .clear_n  (clear_n),
        .preset_n (preset_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .op       (op)
    );

    cnt_next #(.WIDTH(WIDTH), .TOP(TOP)) u_next (
        .op         (op),
        .cur        (value),
        .preset_val (preset_val),
        .nxt        (nxt)
    );

    cnt_state #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_state (
        .clock   (clock),
        .clear_n (clear_n),
        .nxt     (nxt),
        .q       (value)
    );

    cnt_carry #(.WIDTH(WIDTH), .TOP(TOP)) u_carry (
        .q         (value),
        .chain_en  (chain_en),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/cascadable_counter_chk.sv
// Module: cascadable_counter_chk
// Property checker, bound to every cascadable_counter instance.
// Assumes: the clear is held low over at least one rising edge at start-up.
module cascadable_counter_chk #(
    parameter int unsigned WIDTH       = 4,
    parameter bit          DECADE      = 1'b0,
    parameter bit          ASYNC_CLEAR = 1'b0
) (
    input logic             clock,
    input logic             clear_n,
    input logic             preset_n,
    input logic [WIDTH-1:0] preset_val,
    input logic             cnt_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] value,
    input logic             carry_out
);

    localparam logic [WIDTH-1:0] TOP = WIDTH'(cnt_pkg::top_count(DECADE, WIDTH));
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    assert_count_step_R1: assert property (@(posedge clock) disable iff (!clear_n)
        (preset_n && cnt_en && chain_en) |=>
        (value == (($past(value) == TOP) ? '0 : ($past(value) + ONE))));

    assert_hold_R2: assert property (@(posedge clock) disable iff (!clear_n)
        (preset_n && !(cnt_en && chain_en)) |=> $stable(value));

    assert_preset_R3: assert property (@(posedge clock) disable iff (!clear_n)
        (!preset_n) |=> (value == $past(preset_val)));

    assert_carry_top_R6: assert property (@(posedge clock) disable iff (!clear_n)
        carry_out |-> (value == TOP));

    assert_carry_gate_R7: assert property (@(posedge clock) disable iff (!clear_n)
        (!chain_en) |-> (!carry_out));

    generate
        if (ASYNC_CLEAR) begin : g_async_chk
            // Between edges, a low clear must already show a zero count.
            always @(negedge clock) begin
                if (clear_n === 1'b0)
                    assert_async_zero_R5: assert (value == '0);
            end
        end else begin : g_sync_chk
            assert_sync_clear_R4: assert property (@(posedge clock)
                (!clear_n) |=> (value == '0));
        end
    endgenerate

endmodule

bind cascadable_counter cascadable_counter_chk #(
    .WIDTH       (WIDTH),
    .DECADE      (DECADE),
    .ASYNC_CLEAR (ASYNC_CLEAR)
) u_chk (
    .clock      (clock),
    .clear_n    (clear_n),
    .preset_n   (preset_n),
    .preset_val (preset_val),
    .cnt_en     (cnt_en),
    .chain_en   (chain_en),
    .value      (value),
    .carry_out  (carry_out)
);

// File: tb/counter_chain.sv
// Module: counter_chain
// Binary counter stages wired with look-ahead carry. For bench use only.
// Stage 0 gets both enables from run. Every higher stage takes stage 0's carry as its count enable, and the carry of the stage just below as its chain enable.
module counter_chain #(
    parameter int unsigned STAGES = 3
) (
    input  logic                  clock,
    input  logic                  clear_n,
    input  logic                  preset_n,
    input  logic [4*STAGES-1:0]   preset_val,
    input  logic                  run,
    output logic [4*STAGES-1:0]   value,
    output logic                  carry_out
);

    logic [STAGES-1:0] cy;
    logic [STAGES-1:0] ep;
    logic [STAGES-1:0] et;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                assign ep[k] = run;
                assign et[k] = run;
            end else begin : g_upper
                assign ep[k] = cy[0];
                assign et[k] = cy[k-1];
            end
            cascadable_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b0)) u_cnt (
                .clock      (clock),
                .clear_n    (clear_n),
                .preset_n   (preset_n),
                .preset_val (preset_val[4*k +: 4]),
                .cnt_en     (ep[k]),
                .chain_en   (et[k]),
                .value      (value[4*k +: 4]),
                .carry_out  (cy[k])
            );
        end
    endgenerate

    assign carry_out = cy[STAGES-1];

endmodule

// File: tb/test_cascadable_counter.sv
// Bench for cascadable_counter. It uses a binary stage with synchronous clear, a decade stage with immediate clear, and a three-stage chain.
module test_cascadable_counter;

    logic       clock = 1'b0;
    logic       b_clear_n = 1'b0;
    logic       d_clear_n = 1'b0;
    logic       preset_n = 1'b1;
    logic [3:0] preset_val = 4'd0;
    logic       cnt_en = 1'b0;
    logic       chain_en = 1'b0;
    logic [3:0] b_value, d_value;
    logic       b_carry, d_carry;

    logic        c_clear_n = 1'b0;
    logic        c_preset_n = 1'b1;
    logic [11:0] c_preset_val = 12'd0;
    logic        c_run = 1'b0;
    logic [11:0] c_value;
    logic        c_carry;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clock = ~clock;

    cascadable_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b0)) i_cascadable_counter (
        .clock(clock), .clear_n(b_clear_n), .preset_n(preset_n), .preset_val(preset_val),
        .cnt_en(cnt_en), .chain_en(chain_en), .value(b_value), .carry_out(b_carry)
    );

    cascadable_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLEAR(1'b1)) i_decade (
        .clock(clock), .clear_n(d_clear_n), .preset_n(preset_n), .preset_val(preset_val),
        .cnt_en(cnt_en), .chain_en(chain_en), .value(d_value), .carry_out(d_carry)
    );

    counter_chain #(.STAGES(3)) i_chain (
        .clock(clock), .clear_n(c_clear_n), .preset_n(c_preset_n), .preset_val(c_preset_val),
        .run(c_run), .value(c_value), .carry_out(c_carry)
    );

    task automatic expect_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one rising edge and return at the following falling edge.
    task automatic step();
        @(posedge clock);
        @(negedge clock);
    endtask

    task automatic preset_both(input logic [3:0] v, input logic ep, input logic et);
        preset_n = 1'b0; preset_val = v; cnt_en = ep; chain_en = et;
        step();
        preset_n = 1'b1;
    endtask

    task automatic t_reset();
        step(); step();
        expect_eq("R4 reset binary value", b_value, 0);
        expect_eq("R5 reset decade value", d_value, 0);
        expect_eq("R6 reset carry", b_carry, 0);
        b_clear_n = 1'b1; d_clear_n = 1'b1; c_clear_n = 1'b1;
    endtask

    task automatic t_binary_seq();
        int exp_seq[6] = '{13, 14, 15, 0, 1, 2};
        preset_both(4'd12, 1'b0, 1'b0);
        expect_eq("R3 preset with enables low", b_value, 12);
        cnt_en = 1'b1; chain_en = 1'b1;
        foreach (exp_seq[i]) begin
            step();
            expect_eq("R8 binary sequence", b_value, exp_seq[i]);
            expect_eq("R6 binary carry", b_carry, (exp_seq[i] == 15) ? 1 : 0);
        end
    endtask

    task automatic t_hold();
        preset_both(4'd15, 1'b1, 1'b1);
        expect_eq("R3 preset with enables high", b_value, 15);
        cnt_en = 1'b0; chain_en = 1'b1;
        step();
        expect_eq("R2 hold, cnt_en low", b_value, 15);
        expect_eq("R6 carry regardless of cnt_en", b_carry, 1);
        cnt_en = 1'b1; chain_en = 1'b0;
        step();
        expect_eq("R2 hold, chain_en low", b_value, 15);
        expect_eq("R6 carry gated by chain_en", b_carry, 0);
        cnt_en = 1'b0;
        #1 chain_en = 1'b1;
        #1 expect_eq("R7 carry rises between edges", b_carry, 1);
        chain_en = 1'b0;
        #1 expect_eq("R7 carry falls between edges", b_carry, 0);
        @(negedge clock);
    endtask

    task automatic t_between_edges();
        #1 preset_n = 1'b0; preset_val = 4'd3; cnt_en = 1'b1; chain_en = 1'b1;
        #1 preset_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;
        expect_eq("R11 no change before edge", b_value, 15);
        step();
        expect_eq("R11 short pulses ignored", b_value, 15);
    endtask

    task automatic t_sync_clear();
        preset_both(4'd9, 1'b0, 1'b0);
        b_clear_n = 1'b0; preset_n = 1'b0; preset_val = 4'd5; cnt_en = 1'b1; chain_en = 1'b1;
        #1 expect_eq("R4 sync clear waits for edge", b_value, 9);
        step();
        expect_eq("R4 clear beats preset", b_value, 0);
        b_clear_n = 1'b1; preset_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;
    endtask

    task automatic t_async_clear();
        preset_both(4'd5, 1'b0, 1'b0);
        expect_eq("R3 decade preset", d_value, 5);
        #1 d_clear_n = 1'b0;
        #1 expect_eq("R5 immediate clear", d_value, 0);
        preset_n = 1'b0; preset_val = 4'd6;
        step();
        expect_eq("R5 clear held over edge", d_value, 0);
        preset_n = 1'b1;
        #1 d_clear_n = 1'b1;
        @(negedge clock);
    endtask

    task automatic t_decade_seq();
        int exp_seq[6] = '{8, 9, 0, 1, 2, 3};
        preset_both(4'd7, 1'b0, 1'b0);
        cnt_en = 1'b1; chain_en = 1'b1;
        foreach (exp_seq[i]) begin
            step();
            expect_eq("R9 decade sequence", d_value, exp_seq[i]);
            expect_eq("R6 decade carry", d_carry, (exp_seq[i] == 9) ? 1 : 0);
        end
    endtask

    task automatic t_decade_high();
        int exp_seq[4] = '{13, 14, 15, 0};
        preset_both(4'd12, 1'b0, 1'b0);
        expect_eq("R10 decade out-of-range preset", d_value, 12);
        cnt_en = 1'b1; chain_en = 1'b1;
        foreach (exp_seq[i]) begin
            step();
            expect_eq("R10 decade out-of-range count", d_value, exp_seq[i]);
            expect_eq("R10 no carry above nine", d_carry, 0);
        end
        cnt_en = 1'b0; chain_en = 1'b0;
    endtask

    task automatic chain_run(input logic [11:0] start, input int cycles);
        logic [11:0] model;
        c_preset_n = 1'b0; c_preset_val = start; c_run = 1'b0;
        step();
        c_preset_n = 1'b1; c_run = 1'b1;
        model = start;
        expect_eq("R12 chain preset", c_value, model);
        for (int i = 0; i < cycles; i++) begin
            step();
            model = model + 12'd1;
            expect_eq("R12 chain count", c_value, model);
            expect_eq("R12 chain carry", c_carry, (model == 12'hFFF) ? 1 : 0);
        end
        c_run = 1'b0;
        step();
        expect_eq("R12 chain hold", c_value, model);
    endtask

    task automatic t_chain();
        chain_run(12'h0FC, 6);
        chain_run(12'hFFB, 8);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        @(negedge clock);
        t_reset();
        t_binary_seq();
        t_hold();
        t_between_edges();
        t_sync_clear();
        t_async_clear();
        t_decade_seq();
        t_decade_high();
        t_chain();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clock);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule